// File: doc/BRIEF.md
# Dual-Interrupt 32-Line GPIO Bank

This block is one bank of 32 general-purpose I/O lines behind a 32-bit register port. Each line can be an input or an output. Input lines are brought into the clock domain through a two-flop synchronizer. Each input line can then raise an event on a rising edge, on a falling edge, on entering a high level or on entering a low level. Every event sets the line's bit in two separate status registers. Each status register has its own enable mask and its own interrupt output, so two processors or two priority paths can each own a subset of the lines.

Level conditions are applied again when software clears status bits, and when it changes the direction or the level-detect settings. A line that is still held at an enabled level therefore cannot be lost by acknowledging it. Both masks, the wakeup enable and the output latch each have a clear alias and a set alias, so one write changes chosen bits without a read-modify-write. Byte and halfword writes are accepted. For ordinary registers the new lane is merged into the current contents. For write-one-to-clear status and for the aliases the lane is shifted into place with zeros elsewhere. A wakeup output is raised on events from lines that are enabled for wakeup, provided the idle configuration allows it.

Top module: `gpio_bank`

## Requirements
- R1: After reset, offset 0x00 reads the revision parameter (default 0x18) and 0x14 reads 1. Direction (0x34) reads all ones, where a 1 marks an input. The second config (0x30) reads 2. Status, masks, detect enables and wakeup enable read 0. irq0, irq1 and wake are low.
- R2: A rising edge on a line with rising detect (0x4C) set, or a falling edge on a line with falling detect (0x48) set, sets that bit in status 0 (0x18) and status 1 (0x28), but only when the line's direction bit is 1. A status bit appears three clock edges after the pad changes.
- R3: A line that goes high with level-high (0x44) set, or goes low with level-low (0x40) set, sets its bit in both status registers.
- R4: irq0 is the OR of status 0 AND mask 0 (0x2C is mask 1, 0x1C is mask 0); irq1 likewise from status 1 and mask 1. The two outputs are independent.
- R5: Writing 1s to a status register clears those bits. If a write clears at least one set bit, every input line that still meets an enabled level condition sets its bit in that status register again.
- R6: A write to direction, level-low or level-high applies the level conditions, using the newly written values, to both status registers in the same cycle.
- R7: Offsets 0x60/0x64 clear/set bits of mask 0, 0x70/0x74 do the same for mask 1, 0x80/0x84 for the wakeup enable (0x20), and 0x90/0x94 for the output latch (0x3C). Reads at an alias return the underlying register.
- R8: Config (0x10) keeps only the bits in 0x1D. Writing it with bit 1 set returns every register except the output latch and the wakeup flag to its reset value, then stores the written value ANDed with 0x1D. The second config keeps bits 2:0.
- R9: wake rises on an event from a line whose wakeup enable bit is set, if config bit 2 is 1 and config bits 4:3 are not 00. Writing offset 0x14 with bit 0 set clears wake.
- R10: bus_size 0 is a byte, 1 a halfword and 2 a word. Write data sits in the low bits of bus_wdata, and the lane is bus_addr[1:0]. For ordinary registers only that lane changes. Reads return the word shifted right by 8 times the lane.
- R11: For status clears (0x18, 0x28) and for all aliases, a narrow write acts with its data shifted into the lane and zeros in all other lanes.
- R12: If a pin event and a status clear hit the same bit in the same cycle, the bit stays set. If the wakeup clear and a wakeup event coincide, wake stays high.
- R13: Offset 0x38 reads the synchronized pad levels. pad_out always shows the output latch, and pad_dir shows the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address inside the bank |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output latch |
| pad_dir | output | 32 | Direction, 1 = input |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |
| wake | output | 1 | Wakeup request level |

## Verification
Two functions can land on the same edge: a detected pin edge and a software write-one-to-clear of the same status bit. The same applies to a wakeup event and the wakeup clear. The bench counts the synchronizer stages and changes the pad exactly three edges before a clear write to that bit. It then requires the bit to read back as set in both status registers. A second clear with no pending event must empty the bit. The outcome of that pair is what separates "event wins" from a design that lets the clear override the event.

// File: rtl/gpio_bank_pkg.sv
// Package: shared constants and types for the GPIO bank.
// Assumes a 32-bit register word and byte addresses inside an 8-bit window.
package gpio_bank_pkg;
    localparam int unsigned NL = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    localparam logic [7:0] OFF_REV   = 8'h00;
    localparam logic [7:0] OFF_CFG0  = 8'h10;
    localparam logic [7:0] OFF_STAT  = 8'h14;
    localparam logic [7:0] OFF_ST0   = 8'h18;
    localparam logic [7:0] OFF_MK0   = 8'h1C;
    localparam logic [7:0] OFF_WKE   = 8'h20;
    localparam logic [7:0] OFF_ST1   = 8'h28;
    localparam logic [7:0] OFF_MK1   = 8'h2C;
    localparam logic [7:0] OFF_CFG1  = 8'h30;
    localparam logic [7:0] OFF_DIR   = 8'h34;
    localparam logic [7:0] OFF_DIN   = 8'h38;
    localparam logic [7:0] OFF_DOUT  = 8'h3C;
    localparam logic [7:0] OFF_LLO   = 8'h40;
    localparam logic [7:0] OFF_LHI   = 8'h44;
    localparam logic [7:0] OFF_FALL  = 8'h48;
    localparam logic [7:0] OFF_RISE  = 8'h4C;
    localparam logic [7:0] OFF_DBEN  = 8'h50;
    localparam logic [7:0] OFF_DBTM  = 8'h54;
    localparam logic [7:0] OFF_MK0C  = 8'h60;
    localparam logic [7:0] OFF_MK0S  = 8'h64;
    localparam logic [7:0] OFF_MK1C  = 8'h70;
    localparam logic [7:0] OFF_MK1S  = 8'h74;
    localparam logic [7:0] OFF_WKEC  = 8'h80;
    localparam logic [7:0] OFF_WKES  = 8'h84;
    localparam logic [7:0] OFF_DOC   = 8'h90;
    localparam logic [7:0] OFF_DOS   = 8'h94;

    localparam logic [4:0] CFG0_KEEP = 5'h1D;
    localparam logic [2:0] CFG1_RST  = 3'd2;
endpackage

// File: rtl/gpio_in_stage.sv
// Module: synchronizes pad levels and flags per-line edge and level events.
// Assumes pads are asynchronous; events are qualified by direction (1 = input).
module gpio_in_stage #(
    parameter int unsigned W          = 32,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] hi_en,
    input  logic [W-1:0] lo_en,
    output logic [W-1:0] pin_q,
    output logic [W-1:0] ev
);
    logic [W-1:0] sync_q [SYNC_DEPTH];
    logic [W-1:0] prev_q;
    logic [W-1:0] rose, fell;

    // Synchronizer chain followed by one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(SYNC_DEPTH); i++) sync_q[i] <= '0;
            prev_q <= '0;
        end else begin
            sync_q[0] <= pad_in;
            for (int i = 1; i < int'(SYNC_DEPTH); i++) sync_q[i] <= sync_q[i-1];
            prev_q <= sync_q[SYNC_DEPTH-1];
        end
    end

    assign pin_q = sync_q[SYNC_DEPTH-1];

    // Event: any enabled transition kind on an input line.
    always_comb begin
        rose = pin_q & ~prev_q;
        fell = ~pin_q & prev_q;
        ev   = dir & ((rose & (rise_en | hi_en)) | (fell & (fall_en | lo_en)));
    end
endmodule

// File: rtl/gpio_wr_merge.sv
// Module: forms the full-word write value for byte, halfword and word writes.
// Assumes right-aligned write data; merge_en selects lane merge vs zero fill.
module gpio_wr_merge
    import gpio_bank_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] wdata,
    input  logic [1:0]   lane,
    input  xfer_size_e   size,
    input  logic         merge_en,
    output logic [W-1:0] wval
);
    localparam int unsigned SHW = $clog2(W);

    logic [W-1:0]   lmask, lval, lpos;
    logic [SHW-1:0] sh;

    // Lane mask, shift and merge in one combinational step.
    always_comb begin
        unique case (size)
            SZ_BYTE: lmask = {{(W-8){1'b0}}, 8'hFF};
            SZ_HALF: lmask = {{(W-16){1'b0}}, 16'hFFFF};
            default: lmask = '1;
        endcase
        sh   = (size == SZ_BYTE || size == SZ_HALF) ? SHW'({lane, 3'b000}) : '0;
        lval = (wdata & lmask) << sh;
        lpos = lmask << sh;
        wval = merge_en ? ((cur & ~lpos) | lval) : lval;
    end
endmodule

// File: rtl/gpio_irq_unit.sv
// Module: one status/mask pair with its interrupt output.
// Assumes at most one mask operation per cycle; soft_rst clears both registers.
module gpio_irq_unit #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_rst,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] lvl,
    input  logic         lvl_re,
    input  logic         clr_we,
    input  logic         mk_we,
    input  logic         mk_clr,
    input  logic         mk_set,
    input  logic [W-1:0] wval,
    output logic [W-1:0] status,
    output logic [W-1:0] mask,
    output logic         irq
);
    logic [W-1:0] clr_v, lvl_v;
    logic         do_lvl;

    // Clear vector and level re-application enable.
    always_comb begin
        clr_v  = clr_we ? wval : '0;
        do_lvl = lvl_re | (clr_we & (|(status & wval)));
        lvl_v  = do_lvl ? lvl : '0;
    end

    // Status and mask registers; set sources win over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= (status & ~clr_v) | ev | lvl_v;
            if (mk_we)       mask <= wval;
            else if (mk_clr) mask <= mask & ~wval;
            else if (mk_set) mask <= mask | wval;
        end
    end

    assign irq = |(status & mask);
endmodule

// File: rtl/gpio_bank.sv
// Module: top of the 32-line GPIO bank: register file, decode, wakeup.
// Assumes single-cycle register access; reads are combinational on bus_addr.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter logic [7:0]  REV_ID     = 8'h18,
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [7:0]    bus_addr,
    input  logic [1:0]    bus_size,
    input  logic [NL-1:0] bus_wdata,
    output logic [NL-1:0] bus_rdata,
    input  logic [NL-1:0] pad_in,
    output logic [NL-1:0] pad_out,
    output logic [NL-1:0] pad_dir,
    output logic          irq0,
    output logic          irq1,
    output logic          wake
);
    localparam int unsigned NIRQ = 2;

    logic [7:0]    waddr;
    logic          wr, shift_cls, soft_rst, lvl_re, wake_hit, wake_clr;
    logic [NL-1:0] rd_word, wv, pin_q, ev, lvl;
    logic [NL-1:0] dir_q, dout_q, lo_q, hi_q, fall_q, rise_q, wke_q, dben_q;
    logic [NL-1:0] nxt_dir, nxt_lo, nxt_hi;
    logic [7:0]    dbtm_q;
    logic [4:0]    cfg0_q;
    logic [2:0]    cfg1_q;
    logic [NIRQ-1:0] st_clr, mk_wr, mk_clr, mk_set, irq_v;
    logic [NIRQ-1:0][NL-1:0] st_q, mk_q;

    assign waddr = {bus_addr[7:2], 2'b00};
    assign wr    = bus_sel & bus_we;

    // Registers whose narrow writes are zero-filled instead of merged.
    always_comb begin
        unique case (waddr)
            OFF_STAT, OFF_ST0, OFF_ST1, OFF_MK0C, OFF_MK0S, OFF_MK1C,
            OFF_MK1S, OFF_WKEC, OFF_WKES, OFF_DOC, OFF_DOS: shift_cls = 1'b1;
            default: shift_cls = 1'b0;
        endcase
    end

    gpio_wr_merge #(.W(NL)) u_merge (
        .cur(rd_word), .wdata(bus_wdata), .lane(bus_addr[1:0]),
        .size(xfer_size_e'(bus_size)), .merge_en(!shift_cls), .wval(wv)
    );

    gpio_in_stage #(.W(NL), .SYNC_DEPTH(SYNC_DEPTH)) u_in (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .dir(dir_q),
        .rise_en(rise_q), .fall_en(fall_q), .hi_en(hi_q), .lo_en(lo_q),
        .pin_q(pin_q), .ev(ev)
    );

    // Per-unit write strobes: unit 0 then unit 1.
    assign soft_rst  = wr && waddr == OFF_CFG0 && wv[1];
    assign st_clr    = {wr && waddr == OFF_ST1,  wr && waddr == OFF_ST0};
    assign mk_wr     = {wr && waddr == OFF_MK1,  wr && waddr == OFF_MK0};
    assign mk_clr    = {wr && waddr == OFF_MK1C, wr && waddr == OFF_MK0C};
    assign mk_set    = {wr && waddr == OFF_MK1S, wr && waddr == OFF_MK0S};

    // Level conditions evaluated against the values this cycle writes.
    always_comb begin
        nxt_dir = (wr && waddr == OFF_DIR) ? wv : dir_q;
        nxt_lo  = (wr && waddr == OFF_LLO) ? wv : lo_q;
        nxt_hi  = (wr && waddr == OFF_LHI) ? wv : hi_q;
        lvl     = nxt_dir & ((pin_q & nxt_hi) | (~pin_q & nxt_lo));
        lvl_re  = wr && (waddr == OFF_DIR || waddr == OFF_LLO || waddr == OFF_LHI);
    end

    for (genvar g = 0; g < int'(NIRQ); g++) begin : g_irq
        gpio_irq_unit #(.W(NL)) u_unit (
            .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ev(ev), .lvl(lvl),
            .lvl_re(lvl_re), .clr_we(st_clr[g]), .mk_we(mk_wr[g]),
            .mk_clr(mk_clr[g]), .mk_set(mk_set[g]), .wval(wv),
            .status(st_q[g]), .mask(mk_q[g]), .irq(irq_v[g])
        );
    end

    // Configuration, detect and storage registers.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            cfg0_q <= '0;
            cfg1_q <= CFG1_RST;
            wke_q  <= '0;
            dir_q  <= '1;
            lo_q   <= '0;
            hi_q   <= '0;
            fall_q <= '0;
            rise_q <= '0;
            dben_q <= '0;
            dbtm_q <= '0;
            if (soft_rst) cfg0_q <= wv[4:0] & CFG0_KEEP;
        end else if (wr) begin
            unique case (waddr)
                OFF_CFG0: cfg0_q <= wv[4:0] & CFG0_KEEP;
                OFF_CFG1: cfg1_q <= wv[2:0];
                OFF_WKE:  wke_q  <= wv;
                OFF_WKEC: wke_q  <= wke_q & ~wv;
                OFF_WKES: wke_q  <= wke_q | wv;
                OFF_DIR:  dir_q  <= wv;
                OFF_LLO:  lo_q   <= wv;
                OFF_LHI:  hi_q   <= wv;
                OFF_FALL: fall_q <= wv;
                OFF_RISE: rise_q <= wv;
                OFF_DBEN: dben_q <= wv;
                OFF_DBTM: dbtm_q <= wv[7:0];
                default: ;
            endcase
        end
    end

    // Output latch: survives the soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= '0;
        end else if (wr) begin
            unique case (waddr)
                OFF_DOUT: dout_q <= wv;
                OFF_DOC:  dout_q <= dout_q & ~wv;
                OFF_DOS:  dout_q <= dout_q | wv;
                default: ;
            endcase
        end
    end

    assign wake_hit = cfg0_q[2] && (cfg0_q[4:3] != 2'b00) && (|(ev & wke_q));
    assign wake_clr = wr && waddr == OFF_STAT && wv[0];

    // Wakeup flag: set by a qualified event, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        wake <= 1'b0;
        else if (wake_hit) wake <= 1'b1;
        else if (wake_clr) wake <= 1'b0;
    end

    // Read multiplexer; aliases return their underlying register.
    always_comb begin
        unique case (waddr)
            OFF_REV:                    rd_word = {{(NL-8){1'b0}}, REV_ID};
            OFF_CFG0:                   rd_word = {{(NL-5){1'b0}}, cfg0_q};
            OFF_STAT:                   rd_word = {{(NL-1){1'b0}}, 1'b1};
            OFF_ST0:                    rd_word = st_q[0];
            OFF_MK0, OFF_MK0C, OFF_MK0S: rd_word = mk_q[0];
            OFF_WKE, OFF_WKEC, OFF_WKES: rd_word = wke_q;
            OFF_ST1:                    rd_word = st_q[1];
            OFF_MK1, OFF_MK1C, OFF_MK1S: rd_word = mk_q[1];
            OFF_CFG1:                   rd_word = {{(NL-3){1'b0}}, cfg1_q};
            OFF_DIR:                    rd_word = dir_q;
            OFF_DIN:                    rd_word = pin_q;
            OFF_DOUT, OFF_DOC, OFF_DOS: rd_word = dout_q;
            OFF_LLO:                    rd_word = lo_q;
            OFF_LHI:                    rd_word = hi_q;
            OFF_FALL:                   rd_word = fall_q;
            OFF_RISE:                   rd_word = rise_q;
            OFF_DBEN:                   rd_word = dben_q;
            OFF_DBTM:                   rd_word = {{(NL-8){1'b0}}, dbtm_q};
            default:                    rd_word = '0;
        endcase
    end

    assign bus_rdata = rd_word >> {bus_addr[1:0], 3'b000};
    assign pad_out   = dout_q;
    assign pad_dir   = dir_q;
    assign irq0      = irq_v[0];
    assign irq1      = irq_v[1];
endmodule

// File: rtl/gpio_bank_chk.sv
// Module: temporal checks on the GPIO bank, attached through bind.
// Assumes synchronous active-low reset; observes ports and a few internals.
module gpio_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [7:0]  bus_addr,
    input logic [1:0]  bus_size,
    input logic [31:0] bus_wdata,
    input logic        irq0,
    input logic        wake,
    input logic        wake_hit,
    input logic [4:0]  cfg0,
    input logic [31:0] dir,
    input logic [31:0] st0,
    input logic [31:0] st1
);
    AST_MASK0_ZERO_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 8'h1C && bus_size == 2'd2 && bus_wdata == 32'd0)
        |=> !irq0); // R4

    AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 8'h14 && bus_wdata[0] && !wake_hit)
        |=> !wake); // R9

    AST_WAKE_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> ($past(cfg0[2]) && $past(cfg0[4:3]) != 2'b00)); // R9

    AST_SOFT_RESET_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == 8'h10 && bus_wdata[1])
        |=> dir == 32'hFFFF_FFFF); // R8

    AST_ST0_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st0 & ~$past(st0) & ~$past(dir) & ~dir) == 32'd0)); // R2

    AST_ST1_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st1 & ~$past(st1) & ~$past(dir) & ~dir) == 32'd0)); // R2
endmodule

bind gpio_bank gpio_bank_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .irq0(irq0), .wake(wake), .wake_hit(wake_hit), .cfg0(cfg0_q),
    .dir(dir_q), .st0(st_q[0]), .st1(st_q[1])
);

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_dir;
    logic        irq0, irq1, wake;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    gpio_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_dir(pad_dir), .irq0(irq0), .irq1(irq1), .wake(wake)
    );

    function automatic logic [31:0] exp_merge(input logic [31:0] cur, input logic [31:0] wd,
                                              input logic [1:0] lane, input logic [1:0] sz);
        logic [31:0] m;
        m = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
        if (sz == 2'd2) return wd;
        return (cur & ~(m << (lane * 8))) | ((wd & m) << (lane * 8));
    endfunction

    function automatic logic [31:0] exp_shift(input logic [31:0] wd, input logic [1:0] lane,
                                              input logic [1:0] sz);
        logic [31:0] m;
        m = (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
        if (sz == 2'd2) return wd;
        return (wd & m) << (lane * 8);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = 2'd2;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic wait_sync();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] a, b, c, cur, e;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);

        // R1 reset state
        chk_rd("R1 rev", 8'h00, 32'h18);
        chk_rd("R1 stat", 8'h14, 32'h1);
        chk_rd("R1 dir", 8'h34, 32'hFFFF_FFFF);
        chk_rd("R1 cfg1", 8'h30, 32'h2);
        chk_rd("R1 st0", 8'h18, 32'h0);
        chk_rd("R1 mk1", 8'h2C, 32'h0);
        chk_rd("R1 rise", 8'h4C, 32'h0);
        check("R1 irq/wake", {29'd0, irq0, irq1, wake}, 32'h0);

        // R13 input path and output latch, random
        for (int i = 0; i < 6; i++) begin
            a = $urandom;
            pad_in = a; wait_sync();
            chk_rd("R13 din", 8'h38, a);
            b = $urandom;
            wr(8'h3C, 2'd2, b);
            check("R13 pad_out", pad_out, b);
            check("R13 pad_dir", pad_dir, 32'hFFFF_FFFF);
        end
        pad_in = '0; wait_sync();

        // R10 sub-word merge on a storage-only register, random
        for (int i = 0; i < 20; i++) begin
            logic [1:0] sz, ln;
            cur = $urandom;
            wr(8'h50, 2'd2, cur);
            sz = 2'($urandom % 2);
            ln = (sz == 2'd0) ? 2'($urandom % 4) : {1'b1 & 1'($urandom), 1'b0};
            a = $urandom;
            wr({6'h14, ln}, sz, a);
            chk_rd("R10 merge", 8'h50, exp_merge(cur, a, ln, sz));
            rd({6'h14, ln}, b);
            check("R10 lane read", b, exp_merge(cur, a, ln, sz) >> (ln * 8));
        end

        // R7 set/clear aliases, random
        for (int i = 0; i < 4; i++) begin
            a = $urandom; b = $urandom; c = $urandom;
            wr(8'h1C, 2'd2, a); wr(8'h60, 2'd2, b); chk_rd("R7 mk0 clr", 8'h60, a & ~b);
            wr(8'h64, 2'd2, c); chk_rd("R7 mk0 set", 8'h1C, (a & ~b) | c);
            wr(8'h2C, 2'd2, a); wr(8'h70, 2'd2, b); chk_rd("R7 mk1 clr", 8'h2C, a & ~b);
            wr(8'h74, 2'd2, c); chk_rd("R7 mk1 set", 8'h74, (a & ~b) | c);
            wr(8'h20, 2'd2, a); wr(8'h80, 2'd2, b); wr(8'h84, 2'd2, c);
            chk_rd("R7 wke", 8'h84, (a & ~b) | c);
            wr(8'h3C, 2'd2, a); wr(8'h90, 2'd2, b); check("R7 dout clr", pad_out, a & ~b);
            wr(8'h94, 2'd2, c); check("R7 dout set", pad_out, (a & ~b) | c);
        end

        // R11 narrow clear alias is zero-filled, not merged
        wr(8'h1C, 2'd2, 32'hFFFF_FFFF);
        wr(8'h62, 2'd1, 32'h0000_00FF);
        chk_rd("R11 mk0 half clr", 8'h1C, 32'hFFFF_FFFF & ~exp_shift(32'hFF, 2'd2, 2'd1));
        wr(8'h1C, 2'd2, 0); wr(8'h2C, 2'd2, 0); wr(8'h20, 2'd2, 0);

        // R2 edges; line 5 is an output and must not register
        wr(8'h34, 2'd2, 32'hFFFF_FFDF);
        wr(8'h4C, 2'd2, (32'd1 << 3) | (32'd1 << 5));
        pad_in = (32'd1 << 3) | (32'd1 << 5); wait_sync();
        chk_rd("R2 rise st0", 8'h18, 32'd1 << 3);
        chk_rd("R2 rise st1", 8'h28, 32'd1 << 3);
        pad_in[7] = 1'b1; wait_sync();
        wr(8'h48, 2'd2, 32'd1 << 7);
        pad_in[7] = 1'b0; wait_sync();
        chk_rd("R2 fall st0", 8'h18, (32'd1 << 3) | (32'd1 << 7));

        // R4 independent interrupt lines; R11 byte status clear
        wr(8'h1C, 2'd2, 32'd1 << 3);
        check("R4 irq0 on", {31'd0, irq0}, 1); check("R4 irq1 off", {31'd0, irq1}, 0);
        wr(8'h2C, 2'd2, 32'd1 << 7);
        check("R4 irq1 on", {31'd0, irq1}, 1);
        wr(8'h18, 2'd0, 32'h08);
        chk_rd("R11 byte w1c", 8'h18, 32'd1 << 7);
        check("R4 irq0 off", {31'd0, irq0}, 0); check("R4 irq1 still", {31'd0, irq1}, 1);
        wr(8'h1C, 2'd2, 0); wr(8'h2C, 2'd2, 0);
        wr(8'h18, 2'd2, 32'hFFFF_FFFF); wr(8'h28, 2'd2, 32'hFFFF_FFFF);
        chk_rd("R5 cleared", 8'h28, 0);

        // R6 level-low write re-applies; R5 clear keeps held level
        wr(8'h40, 2'd2, 32'd1 << 10);
        chk_rd("R6 llo st0", 8'h18, 32'd1 << 10);
        chk_rd("R6 llo st1", 8'h28, 32'd1 << 10);
        wr(8'h18, 2'd2, 32'd1 << 10);
        chk_rd("R5 relevel", 8'h18, 32'd1 << 10);
        wr(8'h40, 2'd2, 0);
        wr(8'h18, 2'd2, 32'd1 << 10); wr(8'h28, 2'd2, 32'd1 << 10);
        chk_rd("R5 level gone", 8'h18, 0);

        // R6 level-high with pad already high, then R5 after release
        pad_in[9] = 1'b1; wait_sync();
        wr(8'h44, 2'd2, 32'd1 << 9);
        chk_rd("R6 lhi st1", 8'h28, 32'd1 << 9);
        pad_in[9] = 1'b0; wait_sync();
        wr(8'h18, 2'd2, 32'd1 << 9); wr(8'h28, 2'd2, 32'd1 << 9);
        chk_rd("R5 low no relevel", 8'h18, 0);
        pad_in[9] = 1'b1; wait_sync();
        chk_rd("R3 goes high", 8'h28, 32'd1 << 9);
        wr(8'h44, 2'd2, 0);
        wr(8'h18, 2'd2, 32'hFFFF_FFFF); wr(8'h28, 2'd2, 32'hFFFF_FFFF);

        // R3 level-low on a falling transition
        pad_in[11] = 1'b1; wait_sync();
        wr(8'h40, 2'd2, 32'd1 << 11);
        chk_rd("R3 no early", 8'h18, 0);
        pad_in[11] = 1'b0; wait_sync();
        chk_rd("R3 goes low", 8'h18, 32'd1 << 11);
        wr(8'h40, 2'd2, 0);
        wr(8'h18, 2'd2, 32'hFFFF_FFFF); wr(8'h28, 2'd2, 32'hFFFF_FFFF);

        // R9 wakeup path
        wr(8'h10, 2'd2, 32'h0C);
        wr(8'h84, 2'd2, 32'd1 << 12);
        wr(8'h4C, 2'd2, (32'd1 << 3) | (32'd1 << 5) | (32'd1 << 12) | (32'd1 << 14));
        pad_in[12] = 1'b1; wait_sync();
        check("R9 wake set", {31'd0, wake}, 1);
        wr(8'h14, 2'd2, 32'h1);
        check("R9 wake clr", {31'd0, wake}, 0);
        wr(8'h10, 2'd2, 32'h04);
        pad_in[12] = 1'b0; wait_sync();
        pad_in[12] = 1'b1; wait_sync();
        check("R9 idle field zero", {31'd0, wake}, 0);
        wr(8'h18, 2'd2, 32'hFFFF_FFFF); wr(8'h28, 2'd2, 32'hFFFF_FFFF);

        // R12 event and clear on the same edge: event wins
        pad_in[14] = 1'b1; wait_sync();
        chk_rd("R12 setup", 8'h18, 32'd1 << 14);
        pad_in[14] = 1'b0; wait_sync();
        pad_in[14] = 1'b1;
        @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
        wr(8'h18, 2'd2, 32'd1 << 14);
        chk_rd("R12 st0 kept", 8'h18, 32'd1 << 14);
        chk_rd("R12 st1 kept", 8'h28, 32'd1 << 14);
        wr(8'h18, 2'd2, 32'd1 << 14);
        chk_rd("R12 later clear", 8'h18, 0);

        // R8 config masking and soft reset
        wr(8'h10, 2'd2, 32'hFD);
        chk_rd("R8 cfg keep", 8'h10, 32'h1D);
        wr(8'h30, 2'd2, 32'hFF);
        chk_rd("R8 cfg1 keep", 8'h30, 32'h7);
        wr(8'h1C, 2'd2, 32'h55);
        e = pad_out;
        wr(8'h10, 2'd2, 32'h02);
        chk_rd("R8 cfg after", 8'h10, 32'h0);
        chk_rd("R8 mk0 reset", 8'h1C, 32'h0);
        chk_rd("R8 dir reset", 8'h34, 32'hFFFF_FFFF);
        chk_rd("R8 cfg1 reset", 8'h30, 32'h2);
        chk_rd("R8 rise reset", 8'h4C, 32'h0);
        chk_rd("R8 st1 reset", 8'h28, 32'h0);
        check("R8 dout kept", pad_out, e);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule